// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a free-running 32.768 kHz timebase into periodic interrupt events for a real-time-clock style peripheral. A 4-bit rate code and an enable bit come from the control registers. Together they choose an interrupt period, which is a power of two of the slow tick. Each time the period elapses, the block pulses an event for one system clock cycle. In that same cycle it asks the status register block to set its periodic flag and its summary interrupt flag, and it raises an interrupt request.

The slow tick arrives as a one-cycle strobe in the system clock domain. An internal 15-bit tick counter advances on every strobe, whatever the configuration. Events fall on multiples of the period of this counter, not a fixed delay after the configuration changes. A new code or enable value therefore reschedules the next event at once. Clearing the flags and the host register bus belong to the neighbouring status block.

Top module: `pirq_rate_gen`

## Requirements
- R1: During and directly after reset, `evt_pulse`, `irq_req` and `stat_set` are all zero, and the tick counter starts from zero. The first event therefore comes after exactly one full period of ticks.
- R2: A rate code of 0 produces no events, whatever the enable bit is.
- R3: While `per_en` is low, no event is produced for any rate code.
- R4: Rate codes 3 to 15 give a period of 2^(code-1) ticks, which is 4 to 16384 ticks.
- R5: Rate code 1 behaves as code 8 (128 ticks), and rate code 2 behaves as code 9 (256 ticks).
- R6: The tick counter advances by one on every tick, modulo 2^15, even while events are disabled. An event occurs exactly on the tick that brings the counter to a multiple of the period. After events are enabled, the first event is therefore at the next boundary, not a full period later.
- R7: A change of rate code or enable applies from the next tick on, without restarting the counter.
- R8: An event appears only in the system clock cycle right after a cycle in which `tick` was high. It lasts one cycle. Cycles without `tick` do not advance the schedule.
- R9: In the cycle of each event, `stat_set` equals 8'hC0 (bit 7 is the summary interrupt flag, bit 6 is the periodic flag) and `irq_req` is high. In every other cycle both are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick | input | 1 | One-cycle strobe at 32.768 kHz |
| rate_code | input | 4 | Periodic rate select code |
| per_en | input | 1 | Periodic interrupt enable |
| evt_pulse | output | 1 | One-cycle periodic event |
| stat_set | output | 8 | Status bit set request (8'hC0 on an event) |
| irq_req | output | 1 | Interrupt request, high together with an event |

## Verification
The bench sweeps every rate code without resetting in between, so the counter carries across configurations and wraps past 2^15. A design that restarts its count on a change of configuration would fire a full period late rather than at the next boundary. Codes 1 and 2 are targeted for the remap: a plain 2^(code-1) would fire every one or two ticks. The bench also widens the gaps between ticks and drops the enable while the counter runs. A design that counts system clocks, or that fires without the enable, then shows extra or misplaced pulses.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int CODE_W = 4;
  localparam int SHIFT_W = 4;
  localparam logic [7:0] STAT_PERIODIC = 8'hC0;

  // log2 of the period in ticks for a non-zero rate code
  function automatic logic [SHIFT_W-1:0] rate_shift(input logic [CODE_W-1:0] code);
    logic [SHIFT_W-1:0] s;
    if (code == 4'd0)       s = 4'd0;
    else if (code <= 4'd2)  s = code + 4'd6;
    else                    s = code - 4'd1;
    return s;
  endfunction
endpackage

// File: rtl/pirq_rate_decode.sv
module pirq_rate_decode
  import pirq_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic [CODE_W-1:0] rate_code,
  input  logic              per_en,
  output logic              active,
  output logic [CNT_W-1:0]  mask
);
  logic [SHIFT_W-1:0] shift_w;

  always_comb begin
    shift_w = rate_shift(rate_code);
    active  = per_en && (rate_code != '0);
  end

  // low 'shift_w' bits of the mask are ones
  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign mask[i] = (SHIFT_W'(i) < shift_w);
  end
endmodule

// File: rtl/pirq_tick_counter.sv
module pirq_tick_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_inc
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_inc = cnt + CNT_W'(1);
    cnt_d   = tick ? cnt_inc : cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == $past(cnt) + CNT_W'(1)));  // R6
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));  // R8
endmodule

// File: rtl/pirq_event_detect.sv
module pirq_event_detect
  import pirq_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             active,
  input  logic [CNT_W-1:0] mask,
  input  logic [CNT_W-1:0] cnt_inc,
  output logic             evt_q,
  output logic [7:0]       stat_q,
  output logic             irq_q
);
  logic       evt_d;
  logic [7:0] stat_d;

  always_comb begin
    evt_d  = tick && active && ((cnt_inc & mask) == '0);
    stat_d = evt_d ? STAT_PERIODIC : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= 1'b0;
      stat_q <= 8'h00;
      irq_q  <= 1'b0;
    end else begin
      evt_q  <= evt_d;
      stat_q <= stat_d;
      irq_q  <= evt_d;
    end
  end

  AST_EVT_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> $past(tick));  // R8
  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |=> !evt_q);  // R8
endmodule

// File: rtl/pirq_rate_gen.sv
module pirq_rate_gen
  import pirq_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              per_en,
  output logic              evt_pulse,
  output logic [7:0]        stat_set,
  output logic              irq_req
);
  logic             active;
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;

  pirq_rate_decode #(.CNT_W(CNT_W)) u_dec (
    .rate_code(rate_code), .per_en(per_en), .active(active), .mask(mask)
  );

  pirq_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .cnt_inc(cnt_inc)
  );

  pirq_event_detect #(.CNT_W(CNT_W)) u_det (
    .clk(clk), .rst_n(rst_n), .tick(tick), .active(active), .mask(mask),
    .cnt_inc(cnt_inc), .evt_q(evt_pulse), .stat_q(stat_set), .irq_q(irq_req)
  );

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_en || rate_code == '0) |=> !evt_pulse);  // R3
  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> ((cnt & $past(mask)) == '0));  // R6
  AST_STATUS_WITH_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_set == STAT_PERIODIC) == evt_pulse);  // R9
  AST_IRQ_WITH_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == evt_pulse);  // R9
endmodule

// File: tb/pirq_rate_gen_bench.sv
module pirq_rate_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic [3:0] rate_code;
  logic       per_en;
  logic       evt_pulse;
  logic [7:0] stat_set;
  logic       irq_req;

  int checks = 0;
  int errors = 0;
  logic [14:0] mcnt = '0;
  int evt_seen = 0;

  always #4 clk = ~clk;

  pirq_rate_gen u_pirq_rate_gen (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rate_code(rate_code),
    .per_en(per_en), .evt_pulse(evt_pulse), .stat_set(stat_set), .irq_req(irq_req)
  );

  function automatic int period_log2(input logic [3:0] c);
    if (c == 4'd1) return 7;
    if (c == 4'd2) return 8;
    return int'(c) - 1;
  endfunction

  task automatic check(input logic exp, input string req);
    checks++;
    if (evt_pulse !== exp || irq_req !== exp || stat_set !== (exp ? 8'hC0 : 8'h00)) begin
      errors++;
      $display("FAIL %s cnt=%0d code=%0d en=%0b: evt=%0b irq=%0b stat=%h expected evt=%0b stat=%h",
               req, mcnt, rate_code, per_en, evt_pulse, irq_req, stat_set,
               exp, exp ? 8'hC0 : 8'h00);
    end
  endtask

  // one system cycle, inputs driven at negedge, outputs checked at next negedge
  task automatic step(input logic t, input string req);
    logic exp;
    logic [14:0] nxt;
    logic [14:0] m;
    nxt = mcnt + 15'd1;
    m = (rate_code == 4'd0) ? 15'd0 : 15'((32'd1 << period_log2(rate_code)) - 1);
    exp = t && per_en && (rate_code != 4'd0) && ((nxt & m) == 15'd0);
    tick = t;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
    if (t) mcnt = nxt;
    if (evt_pulse) evt_seen++;
    check(exp, req);
  endtask

  task automatic run_ticks(input int n, input string req);
    for (int i = 0; i < n; i++) step(1'b1, req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; rate_code = 4'd3; per_en = 1'b1;
    repeat (3) @(negedge clk);
    check(1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, "R1 after reset");
    // R1: first event exactly after 4 ticks for code 3
    evt_seen = 0;
    run_ticks(4, "R1 first period");
    checks++;
    if (evt_seen != 1) begin
      errors++;
      $display("FAIL R1 events in first period: %0d expected 1", evt_seen);
    end
    // R8: gaps between ticks
    for (int i = 0; i < 40; i++) begin
      step(1'b1, "R8 sparse tick");
      step(1'b0, "R8 idle cycle");
      step(1'b0, "R8 idle cycle");
    end
    // R3: enable low, counter keeps running
    per_en = 1'b0;
    run_ticks(37, "R3 disabled");
    // R6: re-enable mid-count, first event at the next boundary
    per_en = 1'b1;
    rate_code = 4'd5;
    run_ticks(40, "R6 enable mid-count");
    // R2: code zero with enable
    rate_code = 4'd0;
    run_ticks(70, "R2 code zero");
    // R7: code changes on the fly
    rate_code = 4'd4; run_ticks(13, "R7 change code");
    rate_code = 4'd3; run_ticks(9, "R7 change code");
    rate_code = 4'd6; run_ticks(50, "R7 change code");
    // R5 / R4: sweep all codes, counter carried across and wrapping
    for (int c = 1; c < 16; c++) begin
      rate_code = 4'(c);
      evt_seen = 0;
      run_ticks((2 << period_log2(4'(c))) + 5, (c <= 2) ? "R5 remapped code" : "R4 code sweep");
      checks++;
      if (evt_seen < 2) begin
        errors++;
        $display("FAIL R4 code %0d events %0d expected at least 2", c, evt_seen);
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule